// File: doc/BRIEF.md
# Sound Memory Access Port

This block gives a processor bus access to a 128-byte sound memory that is also used by a wavetable synthesis engine. The processor sees three register windows that are decoded from a 16-bit bus address. The pointer register is write-only. One write to it loads a 7-bit byte pointer and an auto-increment flag. The data register reads or writes the byte that the pointer selects. When auto-increment is on, every data access moves the pointer on by one, and the pointer wraps from the top of memory back to zero. The sound control register holds the sound-disable flag.

The synthesis engine has its own port on the same memory. Its reads are registered and take effect every cycle. It can also write, which it uses to store back channel state. The memory has only one write path. If both sides write in the same cycle, the processor write is kept and the engine write is dropped. The channel control fields are ordinary bytes inside this memory, so the block has no separate control file.

A bus access starts on the first cycle of the strobe. Holding the strobe high for more cycles does not repeat the access.

Top module: `snd_ram_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, auto-increment is off, `sound_en` is 0, and both read-data outputs are 0.
- R2: A write to the pointer window (address bits 15:11 = 5'b11111) loads write-data bits 6:0 into the pointer and bit 7 into the auto-increment flag.
- R3: A write to the data window (bits 15:11 = 5'b01001) stores the byte at the pointer. A read there puts the byte at the pointer onto `bus_rdata` after the first clock edge of the strobe, and `bus_rdata` holds that value until the next data read.
- R4: With auto-increment on, the pointer advances by one after each data read and after each data write.
- R5: The pointer wraps from 0x7F to 0x00.
- R6: With auto-increment off, data accesses leave the pointer unchanged.
- R7: A strobe held high for several cycles performs exactly one access, which means one store or read and at most one increment.
- R8: A write to the control window (bits 15:11 = 5'b11100) sets `sound_en` to the inverse of write-data bit 6. The other bits of that write have no effect.
- R9: A read of the pointer window or the control window changes neither the pointer nor `bus_rdata`.
- R10: The engine port returns the byte at `syn_addr` on `syn_rdata` one cycle later. An engine write stores `syn_wdata` at `syn_addr`.
- R11: When the processor and the engine write in the same cycle, the processor write takes effect and the engine write is discarded.
- R12: Bus accesses whose address lies outside the three windows have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_stb | input | 1 | Bus strobe; an access starts on its first high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address used for window decode |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Byte returned by the last data-window read |
| sound_en | output | 1 | Sound enabled (the disable flag is clear) |
| syn_addr | input | 7 | Engine byte address |
| syn_we | input | 1 | Engine write enable |
| syn_wdata | input | 8 | Engine write data |
| syn_rdata | output | 8 | Engine read data, registered |

## Verification
The hardest case to reach from the ports is a processor write and an engine write in the same clock edge. It only happens when the first strobe cycle lines up exactly with an engine write, and the result can only be seen by reading the byte back later. The stimulus lines up those two cycles both on the same address and on different addresses. Two other cases get the same treatment: the pointer wrap, reached with a full 128-byte auto-increment burst, and held strobes, stretched over several cycles. A behavioural model in the bench follows each of these cases edge by edge.

// File: rtl/snd_ram_pkg.sv
// Shared types for the sound memory access port.
// Assumes one bus access per strobe and byte-wide data.
package snd_ram_pkg;

    // Register window hit by a bus access
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_DATA = 2'd1,
        WIN_PTR  = 2'd2,
        WIN_CTRL = 2'd3
    } win_e;

    // One decoded bus access, valid for a single cycle
    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ptr_wr;
        logic ctrl_wr;
    } acc_s;

endpackage

// File: rtl/snd_bus_decode.sv
// Finds the rising edge of the bus strobe and turns it into a
// single-cycle access pulse for the window the address hits.
// Assumes the address and write flag are stable while the strobe is high.
module snd_bus_decode
    import snd_ram_pkg::*;
#(
    parameter int          BUS_AW   = 16,
    parameter logic [15:0] WIN_MASK = 16'hF800,
    parameter logic [15:0] DATA_WIN = 16'h4800,
    parameter logic [15:0] PTR_WIN  = 16'hF800,
    parameter logic [15:0] CTRL_WIN = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    output acc_s              acc
);

    logic stb_q;
    logic start;
    win_e win;

    // Remember the strobe level so that a held strobe counts once
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    assign start = stb && !stb_q;

    // Work out which register window the address falls in
    always_comb begin
        if      ((addr & WIN_MASK[BUS_AW-1:0]) == DATA_WIN[BUS_AW-1:0]) win = WIN_DATA;
        else if ((addr & WIN_MASK[BUS_AW-1:0]) == PTR_WIN[BUS_AW-1:0])  win = WIN_PTR;
        else if ((addr & WIN_MASK[BUS_AW-1:0]) == CTRL_WIN[BUS_AW-1:0]) win = WIN_CTRL;
        else                                                           win = WIN_NONE;
    end

    // Produce the access pulses, qualified by the strobe edge
    always_comb begin
        acc.data_rd = start && (win == WIN_DATA) && !we;
        acc.data_wr = start && (win == WIN_DATA) &&  we;
        acc.ptr_wr  = start && (win == WIN_PTR)  &&  we;
        acc.ctrl_wr = start && (win == WIN_CTRL) &&  we;
    end

    // R7: a single access, never two on back-to-back cycles
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.data_rd || acc.data_wr) |=> !(acc.data_rd || acc.data_wr));

    // R12: at most one kind of access is active at a time
    a_r12_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc.data_rd, acc.data_wr, acc.ptr_wr, acc.ctrl_wr}));

endmodule

// File: rtl/snd_ptr_regs.sv
// Holds the byte pointer, the auto-increment flag and the sound-disable
// flag. The pointer advances once per data access when the flag is set.
// Assumes that pointer loads and data accesses never fall in the same cycle.
module snd_ptr_regs
    import snd_ram_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter int DIS_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_s              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              sound_en
);

    localparam int INC_BIT = DATA_W - 1;

    logic              inc_q;
    logic              dis_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              data_acc;

    assign data_acc = acc.data_rd || acc.data_wr;

    // Load the pointer and flag, or step the pointer after a data access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            inc_q <= 1'b0;
        end else if (acc.ptr_wr) begin
            ptr_q <= wdata[ADDR_W-1:0];
            inc_q <= wdata[INC_BIT];
        end else if (data_acc && inc_q) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Capture the sound-disable flag from a control write
    always_ff @(posedge clk) begin
        if (!rst_n)          dis_q <= 1'b1;
        else if (acc.ctrl_wr) dis_q <= wdata[DIS_BIT];
    end

    assign ptr      = ptr_q;
    assign sound_en = !dis_q;

    // R4: one step per data access while auto-increment is on
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && inc_q) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R5: the top address wraps to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && inc_q && (ptr_q == '1)) |=> (ptr_q == '0));

    // R6: no movement while auto-increment is off
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !inc_q) |=> $stable(ptr_q));

    // R8: sound_en follows the inverse of the disable bit
    a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
        acc.ctrl_wr |=> (sound_en == !$past(wdata[DIS_BIT])));

endmodule

// File: rtl/snd_ram_dp.sv
// Sound memory with a processor port and an engine port. Both read
// ports are registered. There is one write path, and the processor wins it.
// Assumes the memory contents are not reset; only the output registers are.
module snd_ram_dp #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_re,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] syn_addr,
    input  logic              syn_we,
    input  logic [DATA_W-1:0] syn_wdata,
    output logic [DATA_W-1:0] syn_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] cpu_rd_q;
    logic [DATA_W-1:0] syn_rd_q;

    // Single write path; the processor takes it over the engine
    always_ff @(posedge clk) begin
        if (cpu_we)      mem[cpu_addr] <= cpu_wdata;
        else if (syn_we) mem[syn_addr] <= syn_wdata;
    end

    // Processor read register, updated only by a data read
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rd_q <= '0;
        else if (cpu_re) cpu_rd_q <= mem[cpu_addr];
    end

    // Engine read register, reloaded every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) syn_rd_q <= '0;
        else        syn_rd_q <= mem[syn_addr];
    end

    assign cpu_rdata = cpu_rd_q;
    assign syn_rdata = syn_rd_q;

    // R11: on a collision the processor byte lands in memory
    a_r11_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && syn_we) |=> (mem[$past(cpu_addr)] == $past(cpu_wdata)));

    // R10: a lone engine write stores its byte
    a_r10_syn_write: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_we && !cpu_we) |=> (mem[$past(syn_addr)] == $past(syn_wdata)));

    // R3: a processor write stores its byte
    a_r3_cpu_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (mem[$past(cpu_addr)] == $past(cpu_wdata)));

endmodule

// File: rtl/snd_ram_port.sv
// Top of the sound memory access port: bus decode, pointer and flag
// registers, and the dual-port sound memory.
// Assumes a single-cycle-or-longer strobe with the address held stable.
module snd_ram_port
    import snd_ram_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          DATA_W   = 8,
    parameter int          BUS_AW   = 16,
    parameter int          DIS_BIT  = 6,
    parameter logic [15:0] WIN_MASK = 16'hF800,
    parameter logic [15:0] DATA_WIN = 16'h4800,
    parameter logic [15:0] PTR_WIN  = 16'hF800,
    parameter logic [15:0] CTRL_WIN = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sound_en,
    input  logic [ADDR_W-1:0] syn_addr,
    input  logic              syn_we,
    input  logic [DATA_W-1:0] syn_wdata,
    output logic [DATA_W-1:0] syn_rdata
);

    acc_s              acc;
    logic [ADDR_W-1:0] ptr;

    snd_bus_decode #(
        .BUS_AW   (BUS_AW),
        .WIN_MASK (WIN_MASK),
        .DATA_WIN (DATA_WIN),
        .PTR_WIN  (PTR_WIN),
        .CTRL_WIN (CTRL_WIN)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (bus_stb),
        .we    (bus_we),
        .addr  (bus_addr),
        .acc   (acc)
    );

    snd_ptr_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DIS_BIT (DIS_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (bus_wdata),
        .ptr      (ptr),
        .sound_en (sound_en)
    );

    snd_ram_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (ptr),
        .cpu_re    (acc.data_rd),
        .cpu_we    (acc.data_wr),
        .cpu_wdata (bus_wdata),
        .cpu_rdata (bus_rdata),
        .syn_addr  (syn_addr),
        .syn_we    (syn_we),
        .syn_wdata (syn_wdata),
        .syn_rdata (syn_rdata)
    );

    // R9: a read of the pointer window leaves bus_rdata alone
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc.data_rd) |=> $stable(bus_rdata));

endmodule

// File: tb/snd_ram_port_bench.sv
// Bench with a behavioural model of the port, compared on every clock.
module snd_ram_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        sound_en;
    logic [6:0]  syn_addr = 7'h0;
    logic        syn_we = 1'b0;
    logic [7:0]  syn_wdata = 8'h0;
    logic [7:0]  syn_rdata;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // model state; -1 marks a byte that has never been written
    int m_mem [128];
    int m_ptr, m_inc, m_en, m_rd, m_srd, m_prev_stb;

    always #10 clk = ~clk;

    snd_ram_port u_snd_ram_port (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sound_en(sound_en), .syn_addr(syn_addr), .syn_we(syn_we),
        .syn_wdata(syn_wdata), .syn_rdata(syn_rdata)
    );

    initial for (int i = 0; i < 128; i++) m_mem[i] = -1;

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_inc = 0; m_en = 0; m_rd = 0; m_srd = 0; m_prev_stb = 0;
        end else begin
            int old_mem [128];
            bit start;
            for (int i = 0; i < 128; i++) old_mem[i] = m_mem[i];
            start = bus_stb && !m_prev_stb;
            m_prev_stb = bus_stb;
            m_srd = old_mem[syn_addr];
            if (start && bus_addr[15:11] == 5'b01001) begin
                if (bus_we) m_mem[m_ptr] = bus_wdata;
                else        m_rd = old_mem[m_ptr];
                if (m_inc) m_ptr = (m_ptr + 1) % 128;
            end else if (start && bus_we && bus_addr[15:11] == 5'b11111) begin
                m_ptr = bus_wdata[6:0];
                m_inc = bus_wdata[7];
            end else if (start && bus_we && bus_addr[15:11] == 5'b11100) begin
                m_en = !bus_wdata[6];
            end
            if (syn_we && !(start && bus_we && bus_addr[15:11] == 5'b01001))
                m_mem[syn_addr] = syn_wdata;
        end
    end

    // compare with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (sound_en !== m_en[0]) begin
                errors++;
                $display("FAIL %s sound_en act=%0d exp=%0d", cur_req, sound_en, m_en);
            end
            if (m_rd >= 0) begin
                checks++;
                if (bus_rdata !== m_rd[7:0]) begin
                    errors++;
                    $display("FAIL %s bus_rdata act=%0h exp=%0h", cur_req, bus_rdata, m_rd);
                end
            end
            if (m_srd >= 0) begin
                checks++;
                if (syn_rdata !== m_srd[7:0]) begin
                    errors++;
                    $display("FAIL %s syn_rdata act=%0h exp=%0h", cur_req, syn_rdata, m_srd);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one bus access with the strobe held for 'hold' cycles
    task automatic bus(input logic [15:0] a, input logic w, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = d; bus_stb = 1'b1;
        repeat (hold) @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int exp);
        bus(16'h4800, 1'b0, 8'h00, 1);
        chk(req, bus_rdata, exp);
    endtask

    function automatic int pat(input int i);
        return (i * 37 + 5) & 255;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", sound_en, 0);
        chk("R1", bus_rdata, 0);
        chk("R1", syn_rdata, 0);

        // R2, R4, R5: fill all bytes with one auto-increment burst
        cur_req = "R4";
        bus(16'hF800, 1'b1, 8'h80, 1);
        for (int i = 0; i < 128; i++) bus(16'h4800, 1'b1, pat(i), 1);
        cur_req = "R5";
        rd_chk("R5", pat(0));
        rd_chk("R4", pat(1));
        cur_req = "R2";
        bus(16'hFFFF, 1'b1, 8'hFE, 1);
        rd_chk("R2", pat(126));
        rd_chk("R5", pat(127));
        rd_chk("R5", pat(0));

        // R6: auto-increment off
        cur_req = "R6";
        bus(16'hF800, 1'b1, 8'h10, 1);
        bus(16'h4800, 1'b1, 8'hAA, 1);
        bus(16'h4800, 1'b1, 8'hBB, 1);
        rd_chk("R6", 8'hBB);
        rd_chk("R6", 8'hBB);
        bus(16'hF800, 1'b1, 8'h11, 1);
        rd_chk("R3", pat(17));

        // R7: held strobes perform one access
        cur_req = "R7";
        bus(16'hF800, 1'b1, 8'hA0, 1);
        bus(16'h4800, 1'b1, 8'h55, 4);
        bus(16'h4800, 1'b0, 8'h00, 5);
        chk("R7", bus_rdata, pat(33));
        bus(16'hF800, 1'b1, 8'h20, 1);
        rd_chk("R7", 8'h55);
        rd_chk("R7", 8'h55);

        // R8: control register
        cur_req = "R8";
        bus(16'hE000, 1'b1, 8'h00, 1);
        chk("R8", sound_en, 1);
        bus(16'hE7FF, 1'b1, 8'hBF, 1);
        chk("R8", sound_en, 1);
        bus(16'hE000, 1'b1, 8'h40, 1);
        chk("R8", sound_en, 0);
        bus(16'hE123, 1'b1, 8'h3F, 1);
        chk("R8", sound_en, 1);

        // R9: reads of write-only windows change nothing
        cur_req = "R9";
        bus(16'hF800, 1'b1, 8'h85, 1);
        rd_chk("R9", pat(5));
        bus(16'hF800, 1'b0, 8'h00, 1);
        bus(16'hE000, 1'b0, 8'h00, 1);
        chk("R9", bus_rdata, pat(5));
        rd_chk("R9", pat(6));

        // R12: out-of-window accesses are ignored
        cur_req = "R12";
        bus(16'h5000, 1'b1, 8'h0F, 1);
        bus(16'h0000, 1'b1, 8'h01, 1);
        bus(16'h47FF, 1'b1, 8'h02, 1);
        rd_chk("R12", pat(7));
        chk("R12", sound_en, 1);

        // R10: engine port write then read
        cur_req = "R10";
        @(negedge clk);
        syn_addr = 7'h30; syn_we = 1'b1; syn_wdata = 8'h77;
        @(negedge clk);
        syn_we = 1'b0;
        @(negedge clk);
        chk("R10", syn_rdata, 8'h77);

        // R11: same-cycle write collision, same address
        cur_req = "R11";
        bus(16'hF800, 1'b1, 8'h40, 1);
        @(negedge clk);
        syn_addr = 7'h40; syn_we = 1'b1; syn_wdata = 8'h99;
        bus_addr = 16'h4800; bus_we = 1'b1; bus_wdata = 8'h66; bus_stb = 1'b1;
        @(negedge clk);
        syn_we = 1'b0; bus_stb = 1'b0;
        rd_chk("R11", 8'h66);
        // different addresses: the engine write is dropped as well
        bus(16'hF800, 1'b1, 8'h41, 1);
        @(negedge clk);
        syn_addr = 7'h42; syn_we = 1'b1; syn_wdata = 8'h99;
        bus_addr = 16'h4800; bus_we = 1'b1; bus_wdata = 8'h67; bus_stb = 1'b1;
        @(negedge clk);
        syn_we = 1'b0; bus_stb = 1'b0;
        bus(16'hF800, 1'b1, 8'h42, 1);
        rd_chk("R11", pat(66));

        // mixed traffic checked against the model every clock
        cur_req = "R3";
        for (int k = 0; k < 600; k++) begin
            int r = (k * 73 + 11) % 97;
            syn_addr = 7'((k * 29) & 127);
            syn_we = (r % 5 == 0);
            syn_wdata = 8'(r * 3);
            case (r % 6)
                0:       bus(16'hF800, 1'b1, 8'(r * 7), 1 + r % 3);
                1, 2:    bus(16'h4800, 1'b1, 8'(r), 1 + r % 2);
                3, 4:    bus(16'h4800, 1'b0, 8'h00, 1 + r % 3);
                default: bus(16'hE000, 1'b1, 8'(r * 5), 1);
            endcase
        end
        syn_we = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule